// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks outstanding cache misses for a non-blocking cache. It holds a fixed pool of entries. Each entry records a block address, an access size in bytes, the time at which it may issue, a thread id, and two flags: in service and valid. Entries that are waiting to be sent downstream are kept in an ordered queue sorted by ready time. The cache controller reads three things from the block each cycle:

- the entry at the head of that queue, shown only once its time has come;
- a combinational exact-address lookup over every allocated entry;
- a combinational byte-range overlap lookup over the waiting entries.

The block accepts one command per clock on `cmdOp`. The commands are allocate, release, mark in service, mark pending, move to front, squash by thread, and drain. A drain command reports through a one-cycle `drainDone` pulse once no entry remains allocated. The free pool behaves as a stack, so the slot freed most recently is the next one handed out. Target lists, data payload, cache arrays and the memory-side protocol are outside this block.

Top module: `mshr_file`

## Requirements
- R1: The pool holds REQ_ENTRIES + RESERVE - 1 entries (5 by default). After reset, `freeCount` equals that number, `svcCount` is 0, `issueValid`, `hitValid` and `ovlValid` are 0, and `allocSlot` is 0.
- R2: Allocate (`cmdOp`=1) takes the slot shown on `allocSlot`, which is the head of the free stack. At reset the stack holds slot 0 upward. Every released slot is pushed on top of the stack. When several slots are released in one cycle, the one latest in allocation order ends on top.
- R3: `hitVec` has bit i set for each valid entry whose address equals `qAddr`. `hitValid` and `hitIdx` give the earliest-allocated of those entries.
- R4: A newly waiting entry is placed after every waiting entry whose ready time is less than or equal to its own, and before the first waiting entry whose ready time is strictly later.
- R5: `ovlValid`/`ovlIdx` name the first waiting entry, in queue order, whose range [addr, addr+size) intersects [qAddr, qAddr+qSize). In-service entries are never reported.
- R6: Mark in service (`cmdOp`=3) on a valid waiting entry removes it from the queue and raises `svcCount` by one. If `cmdNoResp` is 1, the entry is released instead.
- R7: Mark pending (`cmdOp`=4) acts only on an in-service entry. It clears the in-service flag, lowers `svcCount` by one, and puts the entry back into the queue by its ready time as in R4. On any other entry the command is ignored.
- R8: Move to front (`cmdOp`=5) puts a valid waiting entry at the head of the queue. On an in-service entry it has no effect.
- R9: Squash (`cmdOp`=6) releases every valid waiting entry whose thread id equals `cmdTid`. In-service entries of that thread stay allocated.
- R10: Drain (`cmdOp`=7) with nothing allocated pulses `drainDone` in the next cycle. Otherwise `draining` rises, and `drainDone` pulses for one cycle, while `draining` falls, in the cycle after the edge at which the allocated count first becomes zero.
- R11: Release (`cmdOp`=2) of a valid entry frees it. If the entry was waiting, it leaves the queue. If it was in service, `svcCount` drops by one.
- R12: `issueValid` is 1 only when the queue is not empty and the ready time of its head is less than or equal to `nowTick`. `issueIdx` then names that head.
- R13: Allocate with `freeCount` at 0 pulses `allocErr` in the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | Command code (0 none, 1-7 as in the requirements) |
| cmdIdx | input | IDX_W (3) | Target entry for release, service, pending and front |
| cmdAddr | input | ADDR_W (16) | Block address for allocate |
| cmdSize | input | SIZE_W (8) | Access size in bytes for allocate |
| cmdTime | input | TIME_W (16) | Ready time for allocate |
| cmdTid | input | TID_W (2) | Thread id for allocate and squash |
| cmdNoResp | input | 1 | With mark in service: no response expected, release instead |
| nowTick | input | TIME_W (16) | Current time, compared with ready times |
| qAddr | input | ADDR_W (16) | Query address for exact and overlap lookup |
| qSize | input | SIZE_W (8) | Query size for overlap lookup |
| allocSlot | output | IDX_W (3) | Slot the next allocate takes |
| allocErr | output | 1 | Pulse: allocate was refused because the pool was full |
| freeCount | output | CNT_W (3) | Number of free entries |
| svcCount | output | CNT_W (3) | Number of in-service entries |
| hitValid | output | 1 | Exact lookup found an entry |
| hitIdx | output | IDX_W (3) | Earliest-allocated exact match |
| hitVec | output | N (5) | All exact matches |
| ovlValid | output | 1 | Overlap lookup found a waiting entry |
| ovlIdx | output | IDX_W (3) | First overlapping waiting entry |
| issueValid | output | 1 | Queue head is ready to issue |
| issueIdx | output | IDX_W (3) | Queue head |
| draining | output | 1 | Drain requested and not yet complete |
| drainDone | output | 1 | Pulse: drain complete |

## Verification
The checker assumes that `cmdOp` carries at most one command per cycle and that the allocation-size input keeps `addr+size` within one bit beyond ADDR_W. It also assumes the controller never allocates, as a new miss, an address for which it expects a response from an existing entry. The stimulus keeps within these limits: it issues one command per clock, uses sizes far below the address range, and aims release, service and pending commands at slots whose state the bench already knows. It also sends some commands that must be ignored, namely pending on a waiting slot, move to front on an in-service slot, and allocate into a full pool, so that the refusal paths are driven with no assumption broken.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_FREE   = 3'd2,
    OP_SERVE  = 3'd3,
    OP_PEND   = 3'd4,
    OP_FRONT  = 3'd5,
    OP_SQUASH = 3'd6,
    OP_DRAIN  = 3'd7
  } mshrOp_e;

  // strobes from control to the entry store; at most one is set per cycle
  typedef struct packed {
    logic alloc;
    logic serve;
    logic pend;
    logic front;
  } mshrStrb_t;

endpackage

// File: rtl/mshr_ctrl.sv
module mshr_ctrl import mshr_pkg::*; #(
  parameter int N     = 5,
  parameter int TID_W = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2:0]                cmdOp,
  input  logic [IDX_W-1:0]          cmdIdx,
  input  logic [TID_W-1:0]          cmdTid,
  input  logic                      cmdNoResp,
  input  logic [N-1:0]              entValid,
  input  logic [N-1:0]              entSvc,
  input  logic [N-1:0][TID_W-1:0]   entTid,
  input  logic [CNT_W-1:0]          freeCount,
  output mshrStrb_t                 strb,
  output logic [N-1:0]              relMask,
  output logic [CNT_W-1:0]          svcCount,
  output logic                      allocErr,
  output logic                      draining,
  output logic                      drainDone
);

  mshrOp_e          op;
  logic [N-1:0]     sel;
  logic             selValid;
  logic             selSvc;
  logic [CNT_W-1:0] relCnt;
  logic [CNT_W-1:0] relSvcCnt;
  logic [CNT_W-1:0] allocNow;
  logic [CNT_W-1:0] allocNext;

  assign op       = mshrOp_e'(cmdOp);
  assign sel      = (int'(cmdIdx) < N) ? (N'(1) << cmdIdx) : '0;
  assign selValid = |(sel & entValid);
  assign selSvc   = |(sel & entSvc);

  always_comb begin
    strb    = '0;
    relMask = '0;
    unique case (op)
      OP_ALLOC:  strb.alloc = (freeCount != '0);
      OP_FREE:   if (selValid) relMask = sel;
      OP_SERVE:  if (selValid && !selSvc) begin
                   if (cmdNoResp) relMask = sel;
                   else           strb.serve = 1'b1;
                 end
      OP_PEND:   strb.pend  = selValid && selSvc;
      OP_FRONT:  strb.front = selValid && !selSvc;
      OP_SQUASH: for (int i = 0; i < N; i++)
                   relMask[i] = entValid[i] && !entSvc[i] && (entTid[i] == cmdTid);
      default: ;
    endcase
  end

  assign relCnt    = CNT_W'($countones(relMask));
  assign relSvcCnt = CNT_W'($countones(relMask & entSvc));
  assign allocNow  = CNT_W'(N) - freeCount;
  assign allocNext = allocNow + CNT_W'(strb.alloc) - relCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcCount  <= '0;
      allocErr  <= 1'b0;
      draining  <= 1'b0;
      drainDone <= 1'b0;
    end else begin
      svcCount  <= svcCount + CNT_W'(strb.serve) - CNT_W'(strb.pend) - relSvcCnt;
      allocErr  <= (op == OP_ALLOC) && (freeCount == '0);
      drainDone <= 1'b0;
      if (op == OP_DRAIN && allocNow == '0) begin
        drainDone <= 1'b1;
      end else if ((draining || op == OP_DRAIN) && allocNext == '0) begin
        drainDone <= 1'b1;
        draining  <= 1'b0;
      end else if (op == OP_DRAIN) begin
        draining  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mshr_store.sv
module mshr_store import mshr_pkg::*; #(
  parameter int N      = 5,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int TIME_W = 16,
  parameter int TID_W  = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mshrStrb_t                 strb,
  input  logic [N-1:0]              relMask,
  input  logic [IDX_W-1:0]          cmdIdx,
  input  logic [ADDR_W-1:0]         cmdAddr,
  input  logic [SIZE_W-1:0]         cmdSize,
  input  logic [TIME_W-1:0]         cmdTime,
  input  logic [TID_W-1:0]          cmdTid,
  output logic [N-1:0]              entValid,
  output logic [N-1:0]              entSvc,
  output logic [N-1:0][ADDR_W-1:0]  entAddr,
  output logic [N-1:0][SIZE_W-1:0]  entSize,
  output logic [N-1:0][TIME_W-1:0]  entTime,
  output logic [N-1:0][TID_W-1:0]   entTid,
  output logic [N-1:0][IDX_W-1:0]   allocList,
  output logic [CNT_W-1:0]          allocCnt,
  output logic [N-1:0][IDX_W-1:0]   readyList,
  output logic [CNT_W-1:0]          readyCnt,
  output logic [IDX_W-1:0]          freeHead,
  output logic [CNT_W-1:0]          freeCount
);

  logic [N-1:0][IDX_W-1:0] freeList;
  logic [N-1:0][IDX_W-1:0] readyNext, allocNext, freeNext;
  logic [CNT_W-1:0]        readyCntNext, allocCntNext, freeCntNext;
  logic [IDX_W-1:0]        newSlot;

  assign freeHead = freeList[0];
  assign newSlot  = freeList[0];

  // waiting queue: drop removed slots, then insert one at its position
  always_comb begin
    logic [N-1:0][IDX_W-1:0] tmp;
    logic [IDX_W-1:0]        e, insSlot;
    logic [TIME_W-1:0]       insT;
    logic                    insEn, found;
    int                      k, pos;
    tmp = '0;
    k   = 0;
    for (int i = 0; i < N; i++) begin
      e = readyList[i];
      if (i < int'(readyCnt) &&
          !(relMask[e] || ((strb.serve || strb.front) && e == cmdIdx))) begin
        tmp[k] = e;
        k++;
      end
    end
    insEn   = strb.alloc || strb.pend || strb.front;
    insSlot = strb.alloc ? newSlot : cmdIdx;
    insT    = strb.alloc ? cmdTime : entTime[cmdIdx];
    pos     = k;
    found   = 1'b0;
    if (strb.front) begin
      pos = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!found && i < k && entTime[tmp[i]] > insT) begin
          pos   = i;
          found = 1'b1;
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!insEn || i < pos) readyNext[i] = tmp[i];
      else if (i == pos)     readyNext[i] = insSlot;
      else                   readyNext[i] = tmp[(i == 0) ? 0 : i - 1];
    end
    readyCntNext = CNT_W'(k) + CNT_W'(insEn);
  end

  // allocation order list and free stack
  always_comb begin
    logic [N-1:0][IDX_W-1:0] aTmp, freed, fTmp;
    logic [IDX_W-1:0]        e;
    int                      ak, fk;
    aTmp  = '0;
    freed = '0;
    ak    = 0;
    fk    = 0;
    for (int i = 0; i < N; i++) begin
      e = allocList[i];
      if (i < int'(allocCnt)) begin
        if (relMask[e]) begin
          freed[fk] = e;
          fk++;
        end else begin
          aTmp[ak] = e;
          ak++;
        end
      end
    end
    if (strb.alloc && ak < N) begin
      aTmp[ak] = newSlot;
      ak++;
    end
    allocNext    = aTmp;
    allocCntNext = CNT_W'(ak);
    fTmp = freeList;
    if (strb.alloc) begin
      for (int i = 0; i < N - 1; i++) fTmp[i] = freeList[i + 1];
    end
    for (int i = 0; i < N; i++) begin
      if (i < fk) freeNext[i] = freed[fk - 1 - i];
      else        freeNext[i] = fTmp[i - fk];
    end
    freeCntNext = freeCount - CNT_W'(strb.alloc) + CNT_W'(fk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid  <= '0;
      entSvc    <= '0;
      entAddr   <= '0;
      entSize   <= '0;
      entTime   <= '0;
      entTid    <= '0;
      allocList <= '0;
      allocCnt  <= '0;
      readyList <= '0;
      readyCnt  <= '0;
      freeCount <= CNT_W'(N);
      for (int i = 0; i < N; i++) freeList[i] <= IDX_W'(i);
    end else begin
      allocList <= allocNext;
      allocCnt  <= allocCntNext;
      readyList <= readyNext;
      readyCnt  <= readyCntNext;
      freeList  <= freeNext;
      freeCount <= freeCntNext;
      for (int i = 0; i < N; i++) begin
        if (strb.alloc && newSlot == IDX_W'(i)) begin
          entValid[i] <= 1'b1;
          entSvc[i]   <= 1'b0;
          entAddr[i]  <= cmdAddr;
          entSize[i]  <= cmdSize;
          entTime[i]  <= cmdTime;
          entTid[i]   <= cmdTid;
        end else if (relMask[i]) begin
          entValid[i] <= 1'b0;
          entSvc[i]   <= 1'b0;
        end else if (strb.serve && cmdIdx == IDX_W'(i)) begin
          entSvc[i]   <= 1'b1;
        end else if (strb.pend && cmdIdx == IDX_W'(i)) begin
          entSvc[i]   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int N      = 5,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8,
  parameter int TIME_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]              entValid,
  input  logic [N-1:0][ADDR_W-1:0]  entAddr,
  input  logic [N-1:0][SIZE_W-1:0]  entSize,
  input  logic [N-1:0][TIME_W-1:0]  entTime,
  input  logic [N-1:0][IDX_W-1:0]   allocList,
  input  logic [CNT_W-1:0]          allocCnt,
  input  logic [N-1:0][IDX_W-1:0]   readyList,
  input  logic [CNT_W-1:0]          readyCnt,
  input  logic [ADDR_W-1:0]         qAddr,
  input  logic [SIZE_W-1:0]         qSize,
  input  logic [TIME_W-1:0]         nowTick,
  output logic [N-1:0]              hitVec,
  output logic                      hitValid,
  output logic [IDX_W-1:0]          hitIdx,
  output logic                      ovlValid,
  output logic [IDX_W-1:0]          ovlIdx,
  output logic                      issueValid,
  output logic [IDX_W-1:0]          issueIdx
);

  localparam int EXT_W = ADDR_W + 1;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hitVec[g] = entValid[g] && (entAddr[g] == qAddr);
  end

  always_comb begin
    hitValid = 1'b0;
    hitIdx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!hitValid && i < int'(allocCnt) && hitVec[allocList[i]]) begin
        hitValid = 1'b1;
        hitIdx   = allocList[i];
      end
    end
  end

  always_comb begin
    logic [IDX_W-1:0] e;
    logic [EXT_W-1:0] eLo, eHi, qLo, qHi;
    logic             hit;
    ovlValid = 1'b0;
    ovlIdx   = '0;
    qLo      = {1'b0, qAddr};
    qHi      = qLo + EXT_W'(qSize);
    for (int i = 0; i < N; i++) begin
      e   = readyList[i];
      eLo = {1'b0, entAddr[e]};
      eHi = eLo + EXT_W'(entSize[e]);
      hit = (eLo < qLo) ? (eHi > qLo) : (qHi > eLo);
      if (!ovlValid && i < int'(readyCnt) && hit) begin
        ovlValid = 1'b1;
        ovlIdx   = e;
      end
    end
  end

  assign issueIdx   = readyList[0];
  assign issueValid = (readyCnt != '0) && (entTime[readyList[0]] <= nowTick);

endmodule

// File: rtl/mshr_file.sv
module mshr_file import mshr_pkg::*; #(
  parameter int REQ_ENTRIES = 4,
  parameter int RESERVE     = 2,
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 8,
  parameter int TIME_W      = 16,
  parameter int TID_W       = 2,
  localparam int N     = REQ_ENTRIES + RESERVE - 1,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [TIME_W-1:0] cmdTime,
  input  logic [TID_W-1:0]  cmdTid,
  input  logic              cmdNoResp,
  input  logic [TIME_W-1:0] nowTick,
  input  logic [ADDR_W-1:0] qAddr,
  input  logic [SIZE_W-1:0] qSize,
  output logic [IDX_W-1:0]  allocSlot,
  output logic              allocErr,
  output logic [CNT_W-1:0]  freeCount,
  output logic [CNT_W-1:0]  svcCount,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [N-1:0]      hitVec,
  output logic              ovlValid,
  output logic [IDX_W-1:0]  ovlIdx,
  output logic              issueValid,
  output logic [IDX_W-1:0]  issueIdx,
  output logic              draining,
  output logic              drainDone
);

  mshrStrb_t               strb;
  logic [N-1:0]            relMask;
  logic [N-1:0]            entValid, entSvc;
  logic [N-1:0][ADDR_W-1:0] entAddr;
  logic [N-1:0][SIZE_W-1:0] entSize;
  logic [N-1:0][TIME_W-1:0] entTime;
  logic [N-1:0][TID_W-1:0]  entTid;
  logic [N-1:0][IDX_W-1:0]  allocList, readyList;
  logic [CNT_W-1:0]         allocCnt, readyCnt;

  mshr_ctrl #(.N(N), .TID_W(TID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdIdx(cmdIdx), .cmdTid(cmdTid),
    .cmdNoResp(cmdNoResp), .entValid(entValid), .entSvc(entSvc), .entTid(entTid),
    .freeCount(freeCount), .strb(strb), .relMask(relMask), .svcCount(svcCount),
    .allocErr(allocErr), .draining(draining), .drainDone(drainDone)
  );

  mshr_store #(.N(N), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TIME_W(TIME_W),
               .TID_W(TID_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .relMask(relMask), .cmdIdx(cmdIdx),
    .cmdAddr(cmdAddr), .cmdSize(cmdSize), .cmdTime(cmdTime), .cmdTid(cmdTid),
    .entValid(entValid), .entSvc(entSvc), .entAddr(entAddr), .entSize(entSize),
    .entTime(entTime), .entTid(entTid), .allocList(allocList), .allocCnt(allocCnt),
    .readyList(readyList), .readyCnt(readyCnt), .freeHead(allocSlot),
    .freeCount(freeCount)
  );

  mshr_lookup #(.N(N), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TIME_W(TIME_W)) u_look (
    .entValid(entValid), .entAddr(entAddr), .entSize(entSize), .entTime(entTime),
    .allocList(allocList), .allocCnt(allocCnt), .readyList(readyList),
    .readyCnt(readyCnt), .qAddr(qAddr), .qSize(qSize), .nowTick(nowTick),
    .hitVec(hitVec), .hitValid(hitValid), .hitIdx(hitIdx), .ovlValid(ovlValid),
    .ovlIdx(ovlIdx), .issueValid(issueValid), .issueIdx(issueIdx)
  );

endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int N     = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cmdOp,
  input logic [CNT_W-1:0] freeCount,
  input logic [CNT_W-1:0] svcCount,
  input logic             allocErr,
  input logic             hitValid,
  input logic [IDX_W-1:0] hitIdx,
  input logic [N-1:0]     hitVec,
  input logic             drainDone
);

  p_full_alloc_err_r13: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && freeCount == '0) |=> (allocErr && freeCount == '0));

  p_alloc_takes_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && freeCount != '0) |=> (freeCount == $past(freeCount) - 1'b1));

  p_hit_in_vec_r3: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> hitVec[hitIdx]);

  p_no_hit_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitVec == '0));

  p_svc_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(svcCount) + int'(freeCount)) <= N);

  p_done_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |-> (int'(freeCount) == N));

  p_drain_now_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd7 && int'(freeCount) == N) |=> drainDone);

endmodule

bind mshr_file mshr_file_chk #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/mshr_file_tb_top.sv
`timescale 1ns/1ps
module mshr_file_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [2:0]  cmdIdx = '0;
  logic [15:0] cmdAddr = '0;
  logic [7:0]  cmdSize = '0;
  logic [15:0] cmdTime = '0;
  logic [1:0]  cmdTid = '0;
  logic        cmdNoResp = 1'b0;
  logic [15:0] nowTick = 16'd100;
  logic [15:0] qAddr = '0;
  logic [7:0]  qSize = '0;
  logic [2:0]  allocSlot, hitIdx, ovlIdx, issueIdx, freeCount, svcCount;
  logic        allocErr, hitValid, ovlValid, issueValid, draining, drainDone;
  logic [4:0]  hitVec;

  always #2.5 clk = ~clk;

  mshr_file dut_i (.*);

  localparam int F_FREE = 0, F_SVC = 1, F_ISV = 2, F_ISI = 3, F_HV = 4, F_HI = 5,
                 F_HVEC = 6, F_OV = 7, F_OI = 8, F_SLOT = 9, F_ERR = 10,
                 F_DONE = 11, F_DRN = 12;

  typedef struct { string tag; int sel; int val; } item_t;
  item_t sb[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  event  sampleEv;

  function automatic int fieldOf(int sel);
    case (sel)
      F_FREE: return int'(freeCount);
      F_SVC:  return int'(svcCount);
      F_ISV:  return int'(issueValid);
      F_ISI:  return int'(issueIdx);
      F_HV:   return int'(hitValid);
      F_HI:   return int'(hitIdx);
      F_HVEC: return int'(hitVec);
      F_OV:   return int'(ovlValid);
      F_OI:   return int'(ovlIdx);
      F_SLOT: return int'(allocSlot);
      F_ERR:  return int'(allocErr);
      F_DONE: return int'(drainDone);
      default: return int'(draining);
    endcase
  endfunction

  // monitor: compares queued expectations against the outputs
  initial forever begin
    @(sampleEv);
    while (sb.size() > 0) begin
      item_t it;
      int    act;
      it  = sb.pop_front();
      act = fieldOf(it.sel);
      vectors++;
      if (act !== it.val) begin
        miscompares++;
        $display("FAIL %s field %0d actual %0d expected %0d", it.tag, it.sel, act, it.val);
      end
    end
  end

  task automatic expect_(input string tag, input int sel, input int val);
    item_t it;
    it.tag = tag; it.sel = sel; it.val = val;
    sb.push_back(it);
  endtask

  task automatic settle();
    -> sampleEv;
    #0.5;
  endtask

  task automatic doCmd(input int op, input int idx, input int addr, input int size,
                       input int tm, input int tid, input bit nr);
    @(negedge clk);
    cmdOp = 3'(op); cmdIdx = 3'(idx); cmdAddr = 16'(addr); cmdSize = 8'(size);
    cmdTime = 16'(tm); cmdTid = 2'(tid); cmdNoResp = nr;
    @(posedge clk);
    #1;
    cmdOp = '0; cmdNoResp = 1'b0;
  endtask

  task automatic look(input int a, input int s);
    @(negedge clk);
    qAddr = 16'(a); qSize = 8'(s);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #0.5;
    expect_("R1 reset free", F_FREE, 5);
    expect_("R1 reset svc", F_SVC, 0);
    expect_("R1 reset issue", F_ISV, 0);
    expect_("R1 reset hit", F_HV, 0);
    expect_("R1 reset slot", F_SLOT, 0);
    settle();

    doCmd(1, 0, 'h100, 'h40, 50, 1, 0);   // slot 0
    doCmd(1, 0, 'h200, 'h40, 30, 2, 0);   // slot 1
    doCmd(1, 0, 'h100, 'h10, 50, 1, 0);   // slot 2
    doCmd(1, 0, 'h300, 'h20, 200, 1, 0);  // slot 3 ; queue 1,0,2,3
    expect_("R2 free after four", F_FREE, 1);
    expect_("R2 next slot", F_SLOT, 4);
    expect_("R4 head by time", F_ISI, 1);
    expect_("R12 head ready", F_ISV, 1);
    settle();

    look('h100, 4);
    expect_("R3 match vector", F_HVEC, 5'b00101);
    expect_("R3 first alloc", F_HI, 0);
    settle();
    look('h10C, 4);
    expect_("R4 tie keeps order", F_OI, 0);
    settle();
    look('h140, 8);
    expect_("R5 end exclusive", F_OV, 0);
    settle();
    look('h13F, 1);
    expect_("R5 last byte", F_OI, 0);
    settle();

    doCmd(5, 2, 0, 0, 0, 0, 0);           // queue 2,1,0,3
    look('h10C, 4);
    expect_("R8 front head", F_ISI, 2);
    expect_("R8 front overlap", F_OI, 2);
    settle();

    doCmd(3, 2, 0, 0, 0, 0, 0);           // queue 1,0,3
    expect_("R6 svc count", F_SVC, 1);
    expect_("R6 left queue", F_ISI, 1);
    expect_("R5 svc excluded", F_OI, 0);
    settle();

    doCmd(5, 2, 0, 0, 0, 0, 0);
    expect_("R8 svc front ignored", F_ISI, 1);
    expect_("R8 svc count kept", F_SVC, 1);
    settle();

    doCmd(3, 1, 0, 0, 0, 0, 0);           // queue 0,3
    expect_("R6 second svc", F_SVC, 2);
    expect_("R6 new head", F_ISI, 0);
    settle();

    doCmd(4, 1, 0, 0, 0, 0, 0);           // queue 1,0,3
    expect_("R7 pend count", F_SVC, 1);
    expect_("R7 reinsert by time", F_ISI, 1);
    settle();

    doCmd(4, 0, 0, 0, 0, 0, 0);
    expect_("R7 pend on waiting ignored", F_SVC, 1);
    expect_("R7 head kept", F_ISI, 1);
    settle();

    doCmd(1, 0, 'h400, 'h20, 50, 3, 0);   // slot 4 ; queue 1,0,4,3
    expect_("R1 pool of five", F_FREE, 0);
    settle();

    doCmd(1, 0, 'h500, 'h20, 5, 0, 0);
    expect_("R13 alloc err", F_ERR, 1);
    expect_("R13 no state change", F_FREE, 0);
    expect_("R13 head unchanged", F_ISI, 1);
    settle();
    idle();
    expect_("R13 err is pulse", F_ERR, 0);
    settle();

    doCmd(2, 1, 0, 0, 0, 0, 0);           // queue 0,4,3
    expect_("R11 waiting freed", F_ISI, 0);
    expect_("R11 free", F_FREE, 1);
    expect_("R2 freed reused", F_SLOT, 1);
    settle();

    doCmd(2, 0, 0, 0, 0, 0, 0);           // queue 4,3 ; free 0,1
    expect_("R2 latest freed on top", F_SLOT, 0);
    expect_("R4 equal time after", F_ISI, 4);
    settle();

    @(negedge clk); nowTick = 16'd40; #1;
    expect_("R12 not yet ready", F_ISV, 0);
    settle();
    @(negedge clk); nowTick = 16'd50; #1;
    expect_("R12 ready at equal", F_ISV, 1);
    expect_("R12 head idx", F_ISI, 4);
    settle();

    doCmd(2, 2, 0, 0, 0, 0, 0);           // in-service release ; free 2,0,1
    expect_("R11 svc released", F_SVC, 0);
    expect_("R11 free three", F_FREE, 3);
    settle();

    doCmd(1, 0, 'h500, 'h10, 10, 1, 0);   // slot 2
    expect_("R4 earliest time head", F_ISI, 2);
    settle();
    doCmd(1, 0, 'h600, 'h10, 60, 1, 0);   // slot 0 ; queue 2,4,0,3
    doCmd(3, 3, 0, 0, 0, 0, 0);           // queue 2,4,0
    expect_("R6 svc tid1", F_SVC, 1);
    settle();

    doCmd(6, 0, 0, 0, 0, 1, 0);           // frees 2,0 ; free 0,2,1
    look('h300, 4);
    expect_("R9 squash free", F_FREE, 3);
    expect_("R9 svc kept", F_SVC, 1);
    expect_("R9 svc entry alive", F_HI, 3);
    expect_("R9 queue left", F_ISI, 4);
    expect_("R2 multi release order", F_SLOT, 0);
    settle();

    doCmd(7, 0, 0, 0, 0, 0, 0);
    expect_("R10 draining", F_DRN, 1);
    expect_("R10 not done", F_DONE, 0);
    settle();
    doCmd(2, 4, 0, 0, 0, 0, 0);
    expect_("R10 still draining", F_DONE, 0);
    settle();
    doCmd(2, 3, 0, 0, 0, 0, 0);
    expect_("R10 done pulse", F_DONE, 1);
    expect_("R10 drain cleared", F_DRN, 0);
    expect_("R10 empty", F_FREE, 5);
    settle();
    idle();
    expect_("R10 pulse ends", F_DONE, 0);
    settle();
    doCmd(7, 0, 0, 0, 0, 0, 0);
    expect_("R10 immediate", F_DONE, 1);
    expect_("R10 immediate no drain", F_DRN, 0);
    settle();

    doCmd(1, 0, 'h700, 'h10, 0, 0, 0);    // slot 3
    expect_("R2 stack head", F_FREE, 4);
    settle();
    doCmd(3, 3, 0, 0, 0, 0, 1);
    expect_("R6 noresp freed", F_FREE, 5);
    expect_("R6 noresp no svc", F_SVC, 0);
    expect_("R6 noresp slot back", F_SLOT, 3);
    settle();

    idle();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule